// File: doc/BRIEF.md
# Third-Order Bitstream Decimator

This block turns a one-bit oversampled stream into signed 16-bit PCM words. The stream comes from a delta-sigma modulator or a PDM sensor. The modulator's bit clock and data arrive as plain inputs. The block synchronises both to the system clock. It takes one data bit on each rising edge of the bit clock; the modulator launches new data on the falling edge, so the bit is stable there.

Each bit counts as +1 (high) or -1 (low) and feeds a cascade of three wrapping 32-bit integrators, which run at the bit rate. After every 128 bits, the last integrator's value is taken as one decimated sample. That sample passes through three first-difference stages running at the word rate. The result has the response of a length-128 moving average applied three times. It is scaled down, clipped to 16 bits and presented with a one-cycle strobe. A flag marks the words produced before the difference stages have seen a full history. With a 4 MHz bit clock, the word rate is 31.25 kHz.

Top module: `sinc3_decimator`

## Requirements
- R1: One bit is taken for each rising edge of `mod_clk`. The value taken is the `mod_data` level present at that edge, and a high bit counts as +1 while a low bit counts as -1.
- R2: After every 128 bits taken since reset, `pcm_valid` is high for exactly one system clock cycle. `pcm_word` changes only in the cycle that `pcm_valid` is high.
- R3: Word n (n = 1, 2, ...) equals floor(y/64). Here y is the sum, over k = 0..381, of h[k]·b[128n-1-k]. The sequence b holds the ±1 bit values numbered from 0 after reset, with b = 0 before bit 0. The kernel h is a length-128 all-ones sequence convolved with itself three times. The 32-bit accumulators wrap without saturation.
- R4: Words are clipped to the signed 16-bit range. A settled all-high stream (y = 2^21) gives 0x7FFF, and a settled all-low stream gives 0x8000.
- R5: `pcm_settled` is low with words 1 and 2 after reset and high with word 3 and every later word.
- R6: A synchronous active-high `rst` clears every accumulator, the difference-stage history, the bit counter and the settle count. While `rst` is high and in the cycle after, `pcm_word` is 0, `pcm_valid` is 0 and `pcm_settled` is 0. Bits taken before a reset have no effect on words after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_clk | input | 1 | Modulator bit clock; data is taken on its rising edge |
| mod_data | input | 1 | One-bit modulator output |
| pcm_word | output | 16 | Signed decimated output word |
| pcm_valid | output | 1 | One-cycle strobe for a new word |
| pcm_settled | output | 1 | High when the word is based on a complete filter history |

## Verification
A corrupted integrator or difference-stage register does not fade out, because the cascade has no decay. It appears as a permanent offset or a growing ramp in every later word, starting with the next strobe, at most 128 bits later. A bit counter that slips shows up at once as a strobe arriving too early or too late. The bench checks it by matching each word against the expected word for that exact bit boundary. Saturation and settle-flag faults appear on the third word of a steady all-high or all-low stream.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    localparam int unsigned DECIM       = 128;
    localparam int unsigned ORDER       = 3;
    localparam int unsigned ACC_W       = 32;
    localparam int unsigned OUT_W       = 16;
    localparam int unsigned SYNC_STAGES = 2;

    localparam int unsigned CNT_W     = $clog2(DECIM);
    localparam int unsigned GROWTH    = ORDER * $clog2(DECIM);
    localparam int unsigned OUT_SHIFT = GROWTH + 1 - OUT_W;
    localparam int unsigned SET_MAX   = ORDER - 1;
    localparam int unsigned SET_W     = (ORDER > 2) ? $clog2(ORDER) : 1;

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [OUT_W-1:0] pcm_t;

    typedef struct packed {
        logic vld;
        acc_t val;
    } dec_sample_t;

    typedef struct packed {
        logic vld;
        logic settled;
        pcm_t word;
    } pcm_out_t;

    function automatic acc_t bit_to_step(input logic b);
        return b ? acc_t'(1) : acc_t'(-1);
    endfunction

    function automatic pcm_t scale_sat(input acc_t v);
        acc_t sh;
        acc_t hi;
        acc_t lo;
        sh = v >>> OUT_SHIFT;
        hi = acc_t'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
        lo = -hi - acc_t'(1);
        if (sh > hi)
            return pcm_t'(hi[OUT_W-1:0]);
        else if (sh < lo)
            return pcm_t'(lo[OUT_W-1:0]);
        else
            return pcm_t'(sh[OUT_W-1:0]);
    endfunction

endpackage

// File: rtl/sinc3_bit_sampler.sv
module sinc3_bit_sampler
    import sinc3_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic mod_clk,
    input  logic mod_data,
    output logic bit_en,
    output logic bit_val
);

    logic [STAGES:0]   ck_q;
    logic [STAGES-1:0] dt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_q <= '0;
            dt_q <= '0;
        end else begin
            ck_q <= {ck_q[STAGES-1:0], mod_clk};
            dt_q <= {dt_q[STAGES-2:0], mod_data};
        end
    end

    assign bit_en  = ck_q[STAGES-1] & ~ck_q[STAGES];
    assign bit_val = dt_q[STAGES-1];

    AST_ONE_BIT_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> !bit_en); // R1

endmodule

// File: rtl/sinc3_integ_chain.sv
module sinc3_integ_chain
    import sinc3_pkg::*;
#(
    parameter int unsigned N_STAGE = ORDER
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic bit_val,
    output acc_t last_next
);

    acc_t step;
    acc_t acc [N_STAGE];
    acc_t nxt [N_STAGE];

    assign step = bit_to_step(bit_val);

    for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign nxt[g] = acc[g] + step;
        end else begin : g_rest
            assign nxt[g] = acc[g] + nxt[g-1];
        end

        always_ff @(posedge clk) begin
            if (rst)
                acc[g] <= '0;
            else if (bit_en)
                acc[g] <= nxt[g];
        end
    end

    assign last_next = nxt[N_STAGE-1];

    AST_INT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(acc[0])); // R1

endmodule

// File: rtl/sinc3_comb_chain.sv
module sinc3_comb_chain
    import sinc3_pkg::*;
#(
    parameter int unsigned N_STAGE = ORDER
) (
    input  logic        clk,
    input  logic        rst,
    input  dec_sample_t dec_in,
    output pcm_out_t    out_q
);

    acc_t c [N_STAGE+1];
    acc_t d [N_STAGE];
    logic [SET_W-1:0] settle_cnt;

    assign c[0] = dec_in.val;

    for (genvar g = 0; g < N_STAGE; g++) begin : g_diff
        assign c[g+1] = c[g] - d[g];

        always_ff @(posedge clk) begin
            if (rst)
                d[g] <= '0;
            else if (dec_in.vld)
                d[g] <= c[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q      <= '0;
            settle_cnt <= '0;
        end else begin
            out_q.vld <= dec_in.vld;
            if (dec_in.vld) begin
                out_q.word    <= scale_sat(c[N_STAGE]);
                out_q.settled <= (settle_cnt == SET_W'(SET_MAX));
                if (settle_cnt != SET_W'(SET_MAX))
                    settle_cnt <= settle_cnt + SET_W'(1);
            end
        end
    end

    AST_SETTLE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(out_q.settled) |-> out_q.vld); // R5
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dec_in.vld |=> $stable(out_q.word)); // R2

endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
    import sinc3_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_clk,
    input  logic             mod_data,
    output logic [OUT_W-1:0] pcm_word,
    output logic             pcm_valid,
    output logic             pcm_settled
);

    logic        bit_en;
    logic        bit_val;
    acc_t        int_next;
    logic [CNT_W-1:0] bit_cnt;
    dec_sample_t dec;
    pcm_out_t    po;

    sinc3_bit_sampler #(.STAGES(SYNC_STAGES)) u_smp (
        .clk      (clk),
        .rst      (rst),
        .mod_clk  (mod_clk),
        .mod_data (mod_data),
        .bit_en   (bit_en),
        .bit_val  (bit_val)
    );

    sinc3_integ_chain #(.N_STAGE(ORDER)) u_int (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .bit_val   (bit_val),
        .last_next (int_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            dec     <= '0;
        end else begin
            dec.vld <= 1'b0;
            if (bit_en) begin
                if (bit_cnt == CNT_W'(DECIM - 1)) begin
                    bit_cnt <= '0;
                    dec.vld <= 1'b1;
                    dec.val <= int_next;
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
        end
    end

    sinc3_comb_chain #(.N_STAGE(ORDER)) u_comb (
        .clk    (clk),
        .rst    (rst),
        .dec_in (dec),
        .out_q  (po)
    );

    assign pcm_word    = po.word;
    assign pcm_valid   = po.vld;
    assign pcm_settled = po.settled;

    AST_DEC_FROM_BIT: assert property (@(posedge clk) disable iff (rst)
        dec.vld |-> $past(bit_en)); // R2
    AST_OUT_FOLLOWS_DEC: assert property (@(posedge clk) disable iff (rst)
        dec.vld |=> pcm_valid); // R2
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |=> !pcm_valid); // R2
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pcm_valid && !pcm_settled && pcm_word == '0)); // R6

endmodule

// File: tb/sinc3_decimator_tb.sv
module sinc3_decimator_tb;

    localparam int R      = 128;
    localparam int KLEN   = 3 * R - 2;
    localparam int SHIFT  = 6;
    localparam int WD_MAX = 200000;

    typedef struct {
        int word;
        bit settled;
        int idx;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_clk = 1'b0;
    logic        mod_data = 1'b0;
    logic [15:0] pcm_word;
    logic        pcm_valid;
    logic        pcm_settled;

    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    int   h [KLEN];
    int   hist [$];
    exp_t exq [$];
    int   words_seen = 0;
    bit   prev_valid = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    sinc3_decimator u_dut (
        .clk         (clk),
        .rst         (rst),
        .mod_clk     (mod_clk),
        .mod_data    (mod_data),
        .pcm_word    (pcm_word),
        .pcm_valid   (pcm_valid),
        .pcm_settled (pcm_settled)
    );

    function automatic int expected_word(int n);
        int y = 0;
        int q;
        for (int k = 0; k < KLEN; k++) begin
            int idx = n * R - 1 - k;
            if (idx >= 0) y += h[k] * hist[idx];
        end
        q = y >>> SHIFT;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        return q;
    endfunction

    task automatic send_bit(input bit b);
        exp_t e;
        @(negedge clk);
        mod_clk  = 1'b0;
        mod_data = b;
        repeat (2) @(negedge clk);
        mod_clk = 1'b1;
        hist.push_back(b ? 1 : -1);
        if (hist.size() % R == 0) begin
            e.idx     = hist.size() / R;
            e.word    = expected_word(e.idx);
            e.settled = (e.idx >= 3);
            exq.push_back(e);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        mod_clk = 1'b0;
        rst     = 1'b1;
        repeat (4) @(negedge clk);
        n_run++;
        if (pcm_valid !== 1'b0 || pcm_word !== 16'h0 || pcm_settled !== 1'b0) begin
            n_fail++;
            $display("FAIL R6 reset state: valid=%b word=%h settled=%b expected 0/0000/0",
                     pcm_valid, pcm_word, pcm_settled);
        end
        rst = 1'b0;
        hist.delete();
        @(negedge clk);
    endtask

    task automatic drain();
        repeat (12) @(negedge clk);
        n_run++;
        if (exq.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing words: %0d pending, expected 0", exq.size());
            exq.delete();
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (pcm_valid && prev_valid) begin
                n_run++;
                n_fail++;
                $display("FAIL R2 strobe wider than one cycle: actual 2+ expected 1");
            end
            if (pcm_valid) begin
                exp_t e;
                words_seen++;
                n_run++;
                if (exq.size() == 0) begin
                    n_fail++;
                    $display("FAIL R2 unexpected word %h, expected none", pcm_word);
                end else begin
                    e = exq.pop_front();
                    if ($signed(pcm_word) != e.word) begin
                        n_fail++;
                        $display("FAIL R3/R4 word %0d: actual %0d expected %0d",
                                 e.idx, $signed(pcm_word), e.word);
                    end
                    if (pcm_settled != e.settled) begin
                        n_fail++;
                        $display("FAIL R5 word %0d settled: actual %b expected %b",
                                 e.idx, pcm_settled, e.settled);
                    end
                end
            end
        end
        prev_valid = pcm_valid && !rst;
    end

    initial begin
        repeat (WD_MAX) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int b2 [2*R-1];
        for (int k = 0; k < 2 * R - 1; k++)
            b2[k] = ((k + 1) < (2 * R - 1 - k)) ? (k + 1) : (2 * R - 1 - k);
        for (int k = 0; k < KLEN; k++) begin
            h[k] = 0;
            for (int j = 0; j < 2 * R - 1; j++)
                if (k - j >= 0 && k - j < R) h[k] += b2[j];
        end

        // R6 reset state, R4 positive clip, R5 settle
        do_reset();
        for (int i = 0; i < 6 * R; i++) send_bit(1'b1);
        drain();

        // R4 negative clip after fresh reset
        do_reset();
        for (int i = 0; i < 5 * R; i++) send_bit(1'b0);
        drain();

        // R3 alternating pattern
        do_reset();
        for (int i = 0; i < 6 * R; i++) send_bit(i[0]);
        drain();

        // R3 pseudo-random stream without reset
        for (int i = 0; i < 8 * R; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send_bit(lfsr[0]);
        end
        drain();

        // R1 three-quarter density
        for (int i = 0; i < 5 * R; i++) send_bit(i[1:0] != 2'b00);
        drain();

        // R6 reset in the middle of a word: earlier bits must not leak
        for (int i = 0; i < 50; i++) send_bit(1'b0);
        drain();
        do_reset();
        for (int i = 0; i < 4 * R; i++) send_bit(1'b1);
        drain();

        n_run++;
        if (words_seen != 6 + 5 + 6 + 8 + 5 + 4) begin
            n_fail++;
            $display("FAIL R2 word count: actual %0d expected %0d", words_seen, 34);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule